// File: doc/BRIEF.md
# Multi-mode timer output compare channel

This block is one compare channel that sits beside a free-running timer. It watches the timer count and drives one output pin. A 3-bit mode value picks the behaviour: a plain pin that follows a general-purpose level, single edges in either direction, a toggling pin, a single pulse between two compare points, a pulse that repeats every timer period, and pulse-width modulation with or without a fault trip. Each mode has its own starting pin level and its own rule for raising a one-cycle interrupt strobe.

Software writes a mode by presenting it on `mode_sel` together with a one-cycle `mode_wr` strobe. The write puts the channel back to the starting pin level of that mode. Mode writes are expected only while the timer is halted. The timer, the register bus, the interrupt controller and any transfer engine all live outside this block.

Both outputs are registered. They change at the clock edge where the deciding count, strobe or fault level is presented on the inputs.

Top module: `ocmp_channel`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `pin_out` and `irq_pulse` are 0 and the channel is in mode 3'b000.
- R2: In mode 3'b000 `pin_out` equals `gp_level` sampled at the previous edge, and `irq_pulse` stays 0.
- R3: Mode 3'b001 loads the pin to 0. At the first edge where `tmr_cnt == cmp_a` the pin goes to 1 with a single `irq_pulse`. After that the pin holds 1 and no further interrupt occurs.
- R4: Mode 3'b010 loads the pin to 1. At the first edge where `tmr_cnt == cmp_a` the pin goes to 0 with a single `irq_pulse`. After that the pin holds 0.
- R5: Mode 3'b011 keeps the pin level it had before the write. Each edge with `tmr_cnt == cmp_a` inverts the pin and raises `irq_pulse`.
- R6: Mode 3'b100 loads the pin to 0. The pin rises at `tmr_cnt == cmp_a`, then falls at `tmr_cnt == cmp_b` with `irq_pulse`, and then stays 0 for later periods.
- R7: Mode 3'b101 produces the same rise at `cmp_a` and fall at `cmp_b`, repeated in every timer period, with `irq_pulse` on each fall.
- R8: A write of mode 3'b110 or 3'b111 loads the pin to 1 when `cmp_a` is non-zero and to 0 otherwise. The active duty becomes `cmp_a`.
- R9: In the PWM modes the pin falls at `tmr_cnt == duty`. At an edge with `tmr_wrap` high, the duty takes `cmp_b` and the pin is set to (`cmp_b != 0`). A change of `cmp_b` within a period has no effect before the next `tmr_wrap`.
- R10: Mode 3'b110 never raises `irq_pulse`, and the fault input has no effect in it.
- R11: In mode 3'b111 a high-to-low transition of `fault_n` drives the pin to 0 and raises `irq_pulse` for one cycle. The trip is latched: the pin stays 0 across periods and later fault edges, with no further interrupt, until the next mode write.
- R12: Any mode write clears a completed one-shot, so the same mode runs again from its starting level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_cnt | input | CW | Timer count value |
| tmr_wrap | input | 1 | Timer period-match strobe |
| cmp_a | input | CW | Primary compare value |
| cmp_b | input | CW | Secondary compare value / next duty |
| gp_level | input | 1 | Pin level used in mode 3'b000 |
| fault_n | input | 1 | Active-low fault input, trips on falling edge |
| mode_sel | input | 3 | Mode value to load |
| mode_wr | input | 1 | One-cycle mode write strobe |
| pin_out | output | 1 | Compare output pin |
| irq_pulse | output | 1 | One-cycle interrupt strobe |

## Verification
The bench sweeps every compare position over a short timer period for the edge and pulse modes. This catches an off-by-one compare, which would move the pin edge by one count, and a one-shot that fails to stay done, which would fire again in the second period. For PWM it covers every pairing of starting duty and next duty, including zero and full-period values. It also rewrites the next duty in the middle of a period, so a design that copies the duty early would cut the current pulse short. The fault test drops the fault input more than once and raises it again. A latch that clears itself would bring the pin back high, and a trip that is not gated would send a second interrupt.

// File: rtl/oc_pkg.sv
`timescale 1ns/1ps
package oc_pkg;
  typedef enum logic [2:0] {
    OCM_OFF      = 3'b000,
    OCM_SHOT_LO  = 3'b001,
    OCM_SHOT_HI  = 3'b010,
    OCM_TOGGLE   = 3'b011,
    OCM_DLY_SHOT = 3'b100,
    OCM_PULSE    = 3'b101,
    OCM_PWM      = 3'b110,
    OCM_PWM_FLT  = 3'b111
  } oc_mode_e;

  localparam int NREF = 3;
  localparam int REF_A    = 0;
  localparam int REF_B    = 1;
  localparam int REF_DUTY = 2;
endpackage

// File: rtl/oc_match.sv
`timescale 1ns/1ps
module oc_match #(
  parameter int CW   = 16,
  parameter int NCMP = 3
) (
  input  logic [CW-1:0]            cnt,
  input  logic [NCMP-1:0][CW-1:0]  refs,
  output logic [NCMP-1:0]          hit
);
  for (genvar i = 0; i < NCMP; i++) begin : g_cmp
    assign hit[i] = (cnt == refs[i]);
  end
endmodule

// File: rtl/oc_duty_reg.sv
`timescale 1ns/1ps
module oc_duty_reg #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_init,
  input  logic [CW-1:0] init_val,
  input  logic          upd,
  input  logic [CW-1:0] upd_val,
  output logic [CW-1:0] duty
);
  always_ff @(posedge clk) begin
    if (rst)            duty <= '0;
    else if (load_init) duty <= init_val;
    else if (upd)       duty <= upd_val;
  end
endmodule

// File: rtl/oc_fault.sv
`timescale 1ns/1ps
module oc_fault (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic clr,
  input  logic fault_n,
  output logic trip,
  output logic tripped
);
  logic prev_q;

  assign trip = en & prev_q & ~fault_n & ~tripped;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= 1'b0;
      tripped <= 1'b0;
    end else begin
      prev_q <= fault_n;
      if (clr)       tripped <= 1'b0;
      else if (trip) tripped <= 1'b1;
    end
  end
endmodule

// File: rtl/ocmp_channel.sv
`timescale 1ns/1ps
module ocmp_channel #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] tmr_cnt,
  input  logic          tmr_wrap,
  input  logic [CW-1:0] cmp_a,
  input  logic [CW-1:0] cmp_b,
  input  logic          gp_level,
  input  logic          fault_n,
  input  logic [2:0]    mode_sel,
  input  logic          mode_wr,
  output logic          pin_out,
  output logic          irq_pulse
);
  import oc_pkg::*;

  oc_mode_e                  mode_q;
  logic                      done_q;
  logic [CW-1:0]             duty;
  logic [NREF-1:0][CW-1:0]   refs;
  logic [NREF-1:0]           hit;
  logic                      fault_trip;
  logic                      fault_tripped;
  logic                      pwm_mode;

  assign pwm_mode        = (mode_q == OCM_PWM) || (mode_q == OCM_PWM_FLT);
  assign refs[REF_A]     = cmp_a;
  assign refs[REF_B]     = cmp_b;
  assign refs[REF_DUTY]  = duty;

  oc_match #(.CW(CW), .NCMP(NREF)) u_match (
    .cnt (tmr_cnt),
    .refs(refs),
    .hit (hit)
  );

  oc_duty_reg #(.CW(CW)) u_duty (
    .clk      (clk),
    .rst      (rst),
    .load_init(mode_wr),
    .init_val (cmp_a),
    .upd      (tmr_wrap & pwm_mode),
    .upd_val  (cmp_b),
    .duty     (duty)
  );

  oc_fault u_fault (
    .clk    (clk),
    .rst    (rst),
    .en     (mode_q == OCM_PWM_FLT),
    .clr    (mode_wr),
    .fault_n(fault_n),
    .trip   (fault_trip),
    .tripped(fault_tripped)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= OCM_OFF;
      pin_out   <= 1'b0;
      irq_pulse <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      irq_pulse <= 1'b0;
      if (mode_wr) begin
        mode_q <= oc_mode_e'(mode_sel);
        done_q <= 1'b0;
        case (oc_mode_e'(mode_sel))
          OCM_OFF:               pin_out <= gp_level;
          OCM_SHOT_HI:           pin_out <= 1'b1;
          OCM_TOGGLE:            pin_out <= pin_out;
          OCM_PWM, OCM_PWM_FLT:  pin_out <= (cmp_a != '0);
          default:               pin_out <= 1'b0;
        endcase
      end else begin
        case (mode_q)
          OCM_OFF: pin_out <= gp_level;
          OCM_SHOT_LO, OCM_SHOT_HI: begin
            if (!done_q && hit[REF_A]) begin
              pin_out   <= (mode_q == OCM_SHOT_LO);
              irq_pulse <= 1'b1;
              done_q    <= 1'b1;
            end
          end
          OCM_TOGGLE: begin
            if (hit[REF_A]) begin
              pin_out   <= ~pin_out;
              irq_pulse <= 1'b1;
            end
          end
          OCM_DLY_SHOT, OCM_PULSE: begin
            if (!done_q) begin
              if (!pin_out && hit[REF_A]) begin
                pin_out <= 1'b1;
              end else if (pin_out && hit[REF_B]) begin
                pin_out   <= 1'b0;
                irq_pulse <= 1'b1;
                done_q    <= (mode_q == OCM_DLY_SHOT);
              end
            end
          end
          default: begin
            if (mode_q == OCM_PWM_FLT && (fault_tripped || fault_trip)) begin
              pin_out   <= 1'b0;
              irq_pulse <= fault_trip;
            end else if (tmr_wrap) begin
              pin_out <= (cmp_b != '0);
            end else if (hit[REF_DUTY]) begin
              pin_out <= 1'b0;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/oc_chk.sv
`timescale 1ns/1ps
module oc_chk (
  input logic       clk,
  input logic       rst,
  input logic       mode_wr,
  input logic [2:0] mode_sel,
  input logic       gp_level,
  input logic       pin_out,
  input logic       irq_pulse,
  input logic [2:0] mode_q,
  input logic       fault_tripped
);
  // R2
  off_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 3'b000 && !mode_wr) |=> (pin_out == $past(gp_level) && !irq_pulse));

  // R10
  pwm_no_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 3'b110 && !mode_wr) |=> !irq_pulse);

  // R11
  fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
    fault_tripped |-> !pin_out);

  // R3
  shot_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 3'b001 && pin_out && !mode_wr) |=> pin_out);

  // R5
  irq_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_pulse && mode_q != 3'b111) |-> (pin_out != $past(pin_out)));

  // R12
  load_low_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_wr && mode_sel == 3'b001) |=> (!pin_out && !irq_pulse));
endmodule

bind ocmp_channel oc_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .mode_wr      (mode_wr),
  .mode_sel     (mode_sel),
  .gp_level     (gp_level),
  .pin_out      (pin_out),
  .irq_pulse    (irq_pulse),
  .mode_q       (mode_q),
  .fault_tripped(fault_tripped)
);

// File: tb/sim_ocmp_channel.sv
`timescale 1ns/1ps
module sim_ocmp_channel;
  localparam int CW = 16;
  localparam int P  = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [CW-1:0] tmr_cnt = '0;
  logic          tmr_wrap = 1'b0;
  logic [CW-1:0] cmp_a = '0;
  logic [CW-1:0] cmp_b = '0;
  logic          gp_level = 1'b0;
  logic          fault_n = 1'b1;
  logic [2:0]    mode_sel = 3'b000;
  logic          mode_wr = 1'b0;
  logic          pin_out;
  logic          irq_pulse;

  int n_run = 0;
  int n_fail = 0;
  bit fin = 1'b0;

  always #2.5 clk = ~clk;

  ocmp_channel #(.CW(CW)) u0 (
    .clk(clk), .rst(rst), .tmr_cnt(tmr_cnt), .tmr_wrap(tmr_wrap),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .gp_level(gp_level), .fault_n(fault_n),
    .mode_sel(mode_sel), .mode_wr(mode_wr), .pin_out(pin_out), .irq_pulse(irq_pulse)
  );

  task automatic chk(input logic got, input logic exp, input string tag);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0b exp=%0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic tick(input int c);
    tmr_cnt  = CW'(c);
    tmr_wrap = (c == P-1);
    @(posedge clk);
    #1;
  endtask

  task automatic load(input logic [2:0] m);
    mode_sel = m;
    mode_wr  = 1'b1;
    tmr_cnt  = '0;
    tmr_wrap = 1'b0;
    @(posedge clk);
    #1;
    mode_wr = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!fin) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    chk(pin_out, 1'b0, "R1 pin in reset");
    chk(irq_pulse, 1'b0, "R1 irq in reset");
    rst = 1'b0;
    tick(0);
    chk(pin_out, 1'b0, "R1 pin after reset");
    chk(irq_pulse, 1'b0, "R1 irq after reset");

    // R2: disabled mode follows gp_level
    load(3'b000);
    for (int i = 0; i < 6; i++) begin
      gp_level = i[0] ^ i[1];
      tick(i);
      chk(pin_out, gp_level, "R2 pin follows gp");
      chk(irq_pulse, 1'b0, "R2 no irq");
    end

    // R3 / R4: one-shots over every compare position
    for (int m = 1; m <= 2; m++) begin
      for (int a = 0; a < P; a++) begin
        cmp_a = CW'(a);
        load(3'(m));
        chk(pin_out, (m == 2), (m == 1) ? "R3 load level" : "R4 load level");
        for (int per = 0; per < 2; per++) begin
          for (int c = 0; c < P; c++) begin
            logic hi;
            tick(c);
            hi = (per > 0) || (c >= a);
            chk(pin_out, (m == 1) ? hi : ~hi, (m == 1) ? "R3 pin" : "R4 pin");
            chk(irq_pulse, (per == 0 && c == a), (m == 1) ? "R3 irq" : "R4 irq");
          end
        end
      end
    end

    // R12: reload re-arms a completed one-shot
    cmp_a = CW'(2);
    load(3'b001);
    for (int c = 0; c < P; c++) tick(c);
    chk(pin_out, 1'b1, "R12 shot done");
    load(3'b001);
    chk(pin_out, 1'b0, "R12 reload clears");
    for (int c = 0; c < 4; c++) begin
      tick(c);
      chk(pin_out, (c >= 2), "R12 fires again");
      chk(irq_pulse, (c == 2), "R12 irq again");
    end

    // R5: toggle keeps entry level, inverts per match
    gp_level = 1'b1;
    load(3'b000);
    tick(0);
    cmp_a = CW'(3);
    load(3'b011);
    chk(pin_out, 1'b1, "R5 keeps level");
    begin
      logic lvl;
      lvl = 1'b1;
      for (int per = 0; per < 3; per++) begin
        for (int c = 0; c < P; c++) begin
          tick(c);
          if (c == 3) lvl = ~lvl;
          chk(pin_out, lvl, "R5 toggle pin");
          chk(irq_pulse, (c == 3), "R5 toggle irq");
        end
      end
    end
    gp_level = 1'b0;

    // R6 / R7: delayed single pulse and repeating pulse
    for (int m = 4; m <= 5; m++) begin
      for (int a = 0; a < P; a++) begin
        for (int b = a + 1; b < P; b++) begin
          cmp_a = CW'(a);
          cmp_b = CW'(b);
          load(3'(m));
          chk(pin_out, 1'b0, (m == 4) ? "R6 load low" : "R7 load low");
          for (int per = 0; per < 2; per++) begin
            for (int c = 0; c < P; c++) begin
              logic act;
              tick(c);
              act = (m == 5) || (per == 0);
              chk(pin_out, act && (c >= a) && (c < b), (m == 4) ? "R6 pin" : "R7 pin");
              chk(irq_pulse, act && (c == b), (m == 4) ? "R6 irq" : "R7 irq");
            end
          end
        end
      end
    end

    // R8 / R9 / R10: PWM, every start duty against every next duty
    for (int a = 0; a < P; a++) begin
      for (int b = 0; b < P; b++) begin
        int d;
        int nb;
        cmp_a = CW'(a);
        cmp_b = CW'(b);
        load(3'b110);
        chk(pin_out, (a != 0), "R8 pwm load level");
        d = a;
        nb = b;
        for (int per = 0; per < 3; per++) begin
          for (int c = 0; c < P; c++) begin
            if (per == 1 && c == 1) begin
              nb = (b + 3) % P;
              cmp_b = CW'(nb);
            end
            fault_n = !(per == 1 && c == 4);
            tick(c);
            if (c == P-1) begin
              chk(pin_out, (nb != 0), "R9 pwm wrap level");
              d = nb;
            end else begin
              chk(pin_out, (d != 0) && (c < d), "R9 pwm duty");
            end
            chk(irq_pulse, 1'b0, "R10 no pwm irq");
          end
        end
      end
    end
    fault_n = 1'b1;

    // R11: fault trip and latch
    cmp_a = CW'(5);
    cmp_b = CW'(5);
    load(3'b111);
    chk(pin_out, 1'b1, "R8 pwm-fault load level");
    tick(0);
    tick(1);
    chk(pin_out, 1'b1, "R11 before fault");
    fault_n = 1'b0;
    tick(2);
    chk(pin_out, 1'b0, "R11 trip pin");
    chk(irq_pulse, 1'b1, "R11 trip irq");
    for (int per = 0; per < 2; per++) begin
      for (int c = (per == 0) ? 3 : 0; c < P; c++) begin
        fault_n = (c % 3) != 0;
        tick(c);
        chk(pin_out, 1'b0, "R11 latched pin");
        chk(irq_pulse, 1'b0, "R11 single irq");
      end
    end
    fault_n = 1'b1;
    tick(0);
    load(3'b111);
    chk(pin_out, 1'b1, "R11 reload clears");
    for (int c = 0; c < 4; c++) begin
      tick(c);
      chk(pin_out, 1'b1, "R11 running again");
    end

    fin = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule